// File: doc/BRIEF.md
# Edge-Counting Input Capture Channel

This block is one input channel of a timer unit. It watches an asynchronous pin, picks out the transitions that match a programmed edge mode, and counts them. At every counted transition it records the value of one of two free-running 16-bit time bases. When the count reaches a programmed limit, it stores that transition's time separately and raises an interrupt status bit.

The host programs three settings with a single-cycle configuration write: edge mode, time base choice and sequencing mode, along with the count limit. Counting starts only when the host sends an initialize service request while the channel priority is nonzero. In single-shot mode the channel stops at the limit. In continual mode the count returns to zero and counting goes on. The interrupt output is the status bit gated by an enable input. A one-cycle clear strobe clears the status bit, in the way a host write of 0 would.

Top module: `tcap_channel`

## Requirements
- R1: The edge mode field `cfgEdgeSel` selects which pin transitions count: 000 none, 001 rising only, 010 falling only, 011 both. A written value with bit 2 set (1xx) leaves the stored mode unchanged.
- R2: The time base field `cfgBaseSel` works as follows. Bits [2:1] = 00 mark the channel as an input; any other value stops all counting. Bit 0 picks the recorded time: 0 selects `timeBaseA` and 1 selects `timeBaseB`.
- R3: Each qualifying transition on an armed channel increments `transCount` and loads `lastTransTime` with the selected time base. A pin change driven before clock edge k appears on the outputs after edge k+2, and not before.
- R4: When a qualifying transition brings the count to `cfgMaxCount`, that transition's time is loaded into `finalTransTime` and `irqStatus` is set.
- R5: In single-shot mode (`cfgContinual` = 0), reaching the limit leaves `transCount` equal to the limit and disarms the channel. Later transitions change no output.
- R6: In continual mode (`cfgContinual` = 1), reaching the limit returns `transCount` to 0 and the channel stays armed.
- R7: A one-cycle `hostValid` with `hostCode` = 01 and `chanPrio` other than 00 arms the channel and clears `transCount`. Other codes are ignored, and so is an init while priority is 00. Priority 00 also blocks counting on an armed channel.
- R8: `irqOut` equals `irqStatus` AND `irqEnable`. A `statusClr` pulse clears `irqStatus` unless a limit hit occurs in the same cycle.
- R9: After reset, all outputs are zero and the channel is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | Asynchronous channel pin |
| timeBaseA | input | 16 | First free-running time base |
| timeBaseB | input | 16 | Second free-running time base |
| cfgWe | input | 1 | Configuration write strobe |
| cfgEdgeSel | input | 3 | Edge mode field |
| cfgBaseSel | input | 3 | Input marker and time base select |
| cfgContinual | input | 1 | 1 = continual, 0 = single shot |
| cfgMaxCount | input | 16 | Transition count limit |
| hostValid | input | 1 | Host service request strobe |
| hostCode | input | 2 | Host service request code (01 = initialize) |
| chanPrio | input | 2 | Channel priority, 00 disables |
| irqEnable | input | 1 | Interrupt enable |
| statusClr | input | 1 | Clears the interrupt status bit |
| transCount | output | 16 | Transitions counted |
| lastTransTime | output | 16 | Time of the latest counted transition |
| finalTransTime | output | 16 | Time of the transition that reached the limit |
| irqStatus | output | 1 | Interrupt status |
| irqOut | output | 1 | Gated interrupt |

## Verification
A pin change passes two synchronizer flops and one delay flop. Count and timestamps therefore change at the third rising edge after the change is driven. Configuration, init and status-clear writes take effect at the first edge. The bench drives every input just after a falling edge. For each transition it checks at the falling edge after the second rising edge that the count has not yet moved. It checks again after the third rising edge, when the new count, times, status and interrupt must be present. The time bases are held steady across each transition, so the expected timestamp does not depend on the exact capture cycle.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  typedef struct packed {
    logic init;
    logic capture;
    logic hitMax;
    logic wrap;
    logic useB;
  } tcap_strobe_t;

  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

  localparam logic [1:0] HOST_INIT = 2'b01;

endpackage

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pinIn,
  input  logic         cfgWe,
  input  logic [2:0]   cfgEdgeSel,
  input  logic [2:0]   cfgBaseSel,
  input  logic         cfgContinual,
  input  logic         hostValid,
  input  logic [1:0]   hostCode,
  input  logic [1:0]   chanPrio,
  input  logic         irqEnable,
  input  logic         statusClr,
  input  logic         reachMax,
  output tcap_strobe_t strb,
  output logic         irqStatus,
  output logic         irqOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinS, pinD;
  logic [1:0] edgeMode;
  logic [2:0] baseReg;
  logic contReg;
  logic active;
  logic rise, fall, edgeHit, initReq, isInput, captureOk;

  // pin synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end

  assign pinS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinD <= 1'b0;
    else       pinD <= pinS;
  end

  assign rise = pinS & ~pinD;
  assign fall = ~pinS & pinD;

  // configuration fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeMode <= EDGE_NONE;
      baseReg  <= 3'b000;
      contReg  <= 1'b0;
    end else if (cfgWe) begin
      if (!cfgEdgeSel[2]) edgeMode <= cfgEdgeSel[1:0];
      baseReg <= cfgBaseSel;
      contReg <= cfgContinual;
    end
  end

  always_comb begin
    unique case (edgeMode)
      EDGE_RISE: edgeHit = rise;
      EDGE_FALL: edgeHit = fall;
      EDGE_BOTH: edgeHit = rise | fall;
      default:   edgeHit = 1'b0;
    endcase
  end

  assign initReq   = hostValid && (hostCode == HOST_INIT) && (chanPrio != 2'b00);
  assign isInput   = (baseReg[2:1] == 2'b00);
  assign captureOk = active && (chanPrio != 2'b00) && isInput && edgeHit && !initReq;

  assign strb.init    = initReq;
  assign strb.capture = captureOk;
  assign strb.hitMax  = captureOk && reachMax;
  assign strb.wrap    = contReg;
  assign strb.useB    = baseReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         active <= 1'b0;
    else if (initReq)                  active <= 1'b1;
    else if (strb.hitMax && !contReg)  active <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             irqStatus <= 1'b0;
    else if (strb.hitMax)  irqStatus <= 1'b1;
    else if (statusClr)    irqStatus <= 1'b0;
  end

  assign irqOut = irqStatus & irqEnable;

  AST_STATUS_FROM_HIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus) |-> $past(strb.hitMax)); // R4

  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hitMax && !strb.wrap) |=> !active); // R5

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr && !strb.hitMax) |=> !irqStatus); // R8

  AST_PRIO_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (chanPrio == 2'b00) |=> $stable(active) || !active); // R7

endmodule

// File: rtl/tcap_datapath.sv
module tcap_datapath
  import tcap_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CNT_W-1:0]  cfgMaxCount,
  input  logic [TIME_W-1:0] timeBaseA,
  input  logic [TIME_W-1:0] timeBaseB,
  input  tcap_strobe_t      strb,
  output logic              reachMax,
  output logic [CNT_W-1:0]  transCount,
  output logic [TIME_W-1:0] lastTransTime,
  output logic [TIME_W-1:0] finalTransTime
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]  maxReg;
  logic [CNT_W-1:0]  countNext;
  logic [TIME_W-1:0] selTime;

  assign selTime   = strb.useB ? timeBaseB : timeBaseA;
  assign countNext = transCount + CNT_ONE;
  assign reachMax  = (countNext == maxReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      maxReg <= '0;
    else if (cfgWe) maxReg <= cfgMaxCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           transCount <= '0;
    else if (strb.init)                  transCount <= '0;
    else if (strb.hitMax && strb.wrap)   transCount <= '0;
    else if (strb.capture)               transCount <= countNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lastTransTime <= '0;
    else if (strb.capture) lastTransTime <= selTime;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            finalTransTime <= '0;
    else if (strb.hitMax) finalTransTime <= selTime;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.hitMax && !strb.init) |=> transCount == $past(transCount) + CNT_ONE); // R3

  AST_FINAL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.hitMax |=> finalTransTime == $past(selTime)); // R4

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capture && !strb.init) |=> $stable(transCount)); // R5

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hitMax && strb.wrap && !strb.init) |=> transCount == '0); // R6

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
  import tcap_pkg::*;
#(
  parameter int TIME_W      = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic [TIME_W-1:0] timeBaseA,
  input  logic [TIME_W-1:0] timeBaseB,
  input  logic              cfgWe,
  input  logic [2:0]        cfgEdgeSel,
  input  logic [2:0]        cfgBaseSel,
  input  logic              cfgContinual,
  input  logic [CNT_W-1:0]  cfgMaxCount,
  input  logic              hostValid,
  input  logic [1:0]        hostCode,
  input  logic [1:0]        chanPrio,
  input  logic              irqEnable,
  input  logic              statusClr,
  output logic [CNT_W-1:0]  transCount,
  output logic [TIME_W-1:0] lastTransTime,
  output logic [TIME_W-1:0] finalTransTime,
  output logic              irqStatus,
  output logic              irqOut
);

  tcap_strobe_t strb;
  logic reachMax;

  tcap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .cfgWe(cfgWe), .cfgEdgeSel(cfgEdgeSel), .cfgBaseSel(cfgBaseSel),
    .cfgContinual(cfgContinual), .hostValid(hostValid), .hostCode(hostCode),
    .chanPrio(chanPrio), .irqEnable(irqEnable), .statusClr(statusClr),
    .reachMax(reachMax), .strb(strb), .irqStatus(irqStatus), .irqOut(irqOut)
  );

  tcap_datapath #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgMaxCount(cfgMaxCount),
    .timeBaseA(timeBaseA), .timeBaseB(timeBaseB), .strb(strb),
    .reachMax(reachMax), .transCount(transCount),
    .lastTransTime(lastTransTime), .finalTransTime(finalTransTime)
  );

endmodule

// File: tb/tcap_channel_tb.sv
module tcap_channel_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinIn = 1'b0;
  logic [15:0] timeBaseA = '0, timeBaseB = '0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgEdgeSel = '0, cfgBaseSel = '0;
  logic cfgContinual = 1'b0;
  logic [15:0] cfgMaxCount = '0;
  logic hostValid = 1'b0;
  logic [1:0] hostCode = '0, chanPrio = '0;
  logic irqEnable = 1'b0, statusClr = 1'b0;
  logic [15:0] transCount, lastTransTime, finalTransTime;
  logic irqStatus, irqOut;

  always #2 clk = ~clk;

  tcap_channel u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .timeBaseA(timeBaseA), .timeBaseB(timeBaseB),
    .cfgWe(cfgWe), .cfgEdgeSel(cfgEdgeSel), .cfgBaseSel(cfgBaseSel),
    .cfgContinual(cfgContinual), .cfgMaxCount(cfgMaxCount), .hostValid(hostValid),
    .hostCode(hostCode), .chanPrio(chanPrio), .irqEnable(irqEnable), .statusClr(statusClr),
    .transCount(transCount), .lastTransTime(lastTransTime), .finalTransTime(finalTransTime),
    .irqStatus(irqStatus), .irqOut(irqOut)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  // bench model state
  logic [1:0]  mEdge = 2'b00;
  logic [2:0]  mBase = 3'b000;
  logic        mCont = 1'b0, mActive = 1'b0, mPin = 1'b0, mStatus = 1'b0;
  logic [15:0] mMax = '0, mCount = '0, mLast = '0, mFinal = '0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll(string tag);
    chk({tag, " R3 count"}, transCount, mCount);
    chk({tag, " R3 last"}, lastTransTime, mLast);
    chk({tag, " R4 final"}, finalTransTime, mFinal);
    chk({tag, " R4 status"}, {15'd0, irqStatus}, {15'd0, mStatus});
    chk({tag, " R8 irq"}, {15'd0, irqOut}, {15'd0, mStatus & irqEnable});
  endtask

  task automatic doCfg(logic [2:0] e, logic [2:0] b, logic c, logic [15:0] mx);
    cfgWe = 1'b1; cfgEdgeSel = e; cfgBaseSel = b; cfgContinual = c; cfgMaxCount = mx;
    cyc();
    cfgWe = 1'b0;
    if (!e[2]) mEdge = e[1:0];
    mBase = b; mCont = c; mMax = mx;
  endtask

  task automatic doHost(logic [1:0] code);
    hostValid = 1'b1; hostCode = code;
    cyc();
    hostValid = 1'b0;
    if (code == 2'b01 && chanPrio != 2'b00) begin
      mActive = 1'b1; mCount = '0;
    end
  endtask

  task automatic doClr();
    statusClr = 1'b1;
    cyc();
    statusClr = 1'b0;
    mStatus = 1'b0;
  endtask

  // one pin transition with the time bases held steady
  task automatic toggle(logic [15:0] ta, logic [15:0] tb);
    logic rise, fall, qual;
    logic [15:0] t;
    timeBaseA = ta; timeBaseB = tb;
    pinIn = ~mPin;
    rise = pinIn & ~mPin;
    fall = ~pinIn & mPin;
    mPin = pinIn;
    cyc(); cyc();
    chk("R3 latency-not-yet", transCount, mCount);
    cyc();
    qual = (mEdge == 2'b01 && rise) || (mEdge == 2'b10 && fall) || (mEdge == 2'b11 && (rise || fall));
    if (qual && mActive && chanPrio != 2'b00 && mBase[2:1] == 2'b00) begin
      t = mBase[0] ? tb : ta;
      mLast = t;
      if (mCount + 16'd1 == mMax) begin
        mFinal = t; mStatus = 1'b1;
        if (mCont) mCount = '0;
        else begin mCount = mMax; mActive = 1'b0; end
      end else mCount = mCount + 16'd1;
    end
    checkAll("toggle");
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    endRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R9 reset");
    rstN = 1'b1;
    cyc();
    checkAll("R9 after-release");

    // R7: init while priority 00 is ignored
    chanPrio = 2'b00;
    doCfg(3'b001, 3'b000, 1'b0, 16'd2);
    doHost(2'b01);
    toggle(16'h0011, 16'h0022);
    toggle(16'h0033, 16'h0044);
    chanPrio = 2'b10;

    // main sweep: R1 R2 R4 R5 R6
    for (int e = 0; e < 4; e++) begin
      for (int c = 0; c < 2; c++) begin
        for (int mx = 1; mx <= 3; mx++) begin
          automatic int combo = e * 6 + c * 3 + (mx - 1);
          automatic logic [2:0] b = (combo % 3 == 0) ? 3'b000 : (combo % 3 == 1) ? 3'b001 : 3'b010;
          irqEnable = combo[0];
          doClr();
          doCfg(3'(e), b, 1'(c), 16'(mx));
          doHost(2'b01);
          checkAll("R7 init");
          for (int i = 0; i < 8; i++) begin
            automatic logic [15:0] ta = 16'(combo * 97 + i * 13 + 5);
            toggle(ta, ta ^ 16'hF0F0);
          end
        end
      end
    end

    // R1: 1xx keeps the previous edge mode (rising)
    irqEnable = 1'b1;
    doCfg(3'b001, 3'b001, 1'b1, 16'd50);
    doCfg(3'b110, 3'b001, 1'b1, 16'd50);
    doHost(2'b01);
    for (int i = 0; i < 6; i++) toggle(16'(i * 3 + 1), 16'(i * 5 + 700));

    // R7: priority 00 blocks an armed channel; other host codes ignored
    chanPrio = 2'b00;
    toggle(16'h0AAA, 16'h0BBB);
    toggle(16'h0CCC, 16'h0DDD);
    chanPrio = 2'b01;
    doHost(2'b10);
    doHost(2'b11);
    checkAll("R7 other-codes");
    toggle(16'h1234, 16'h5678);
    toggle(16'h1235, 16'h5679);

    // R5: single-shot stops, R8 clear and gating
    doCfg(3'b011, 3'b000, 1'b0, 16'd1);
    doHost(2'b01);
    toggle(16'h4321, 16'h0);
    toggle(16'h4322, 16'h0);
    toggle(16'h4323, 16'h0);
    irqEnable = 1'b0;
    cyc();
    checkAll("R8 gated");
    doClr();
    checkAll("R8 cleared");

    endRun();
  end

endmodule